// File: doc/BRIEF.md
# Message-Signalled Interrupt Landing Bank

This block receives inbound message-signalled interrupt writes and holds them as pending vector bits. The vector bits are spread over 16 groups. Each group holds 8 index registers, and each index register holds 16 vector bits, so the bank covers 2048 vectors in all. A sender selects a group and an index register through the write offset, and selects one vector bit through the write data value. The write sets only that bit.

Each group raises one level interrupt line while any of its index registers holds a set bit. A service routine first reads the group's summary register to find the non-empty index registers. It then reads each of those index registers. A read returns the pending vector bits and clears them in the same operation, so pending work is taken exactly once.

The request side is a plain valid/offset/data interface, with one write port and one read port that can both be active in the same cycle. Read data appears on `rd_data` in the cycle after the read request and holds until the next read.

Top module: `msi_term_bank`

## Requirements
- R1: A write with `wr_en` high to byte offset (n << 19) + (x << 16), where n is 0..15 and x is 0..7, with data value d in 0..15 sets bit d of index register x of group n. The other bits of that register and all other registers keep their values.
- R2: A read of index register x of group n, at the same offset as in R1, places its value in `rd_data[15:0]` (upper bits zero) one cycle after the request and clears that register to zero.
- R3: A read of offset 0x800000 + (n << 16) returns the summary of group n in `rd_data[7:0]` (upper bits zero). Bit x of the summary is 1 exactly when index register x of group n is non-zero. The read clears nothing.
- R4: `irq[n]` is high exactly while the summary of group n is non-zero, in the cycle after the write or read that changes it.
- R5: When a write and a read hit the same index register in one cycle, the read returns the value held before that cycle, and afterwards the register holds only the newly written bit.
- R6: A write whose data is 16 or greater changes no register.
- R7: A write to the summary region, to an offset with any of bits 15:0 set, or to an offset with bit 23 set and bits 22:20 non-zero changes no register.
- R8: A read of any offset that is neither an index register nor a summary register returns zero and changes no register.
- R9: A synchronous reset (`rst` high at a clock edge) clears every index register and `rd_data`, which drives all `irq` outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request valid |
| wr_addr | input | 24 | Byte offset of the write |
| wr_data | input | 32 | Write data; the value selects the vector bit |
| rd_en | input | 1 | Read request valid |
| rd_addr | input | 24 | Byte offset of the read |
| rd_data | output | 32 | Read result, updated the cycle after `rd_en` |
| irq | output | 16 | Per-group level interrupt lines |

## Verification
On every cycle, the assertions check four behaviours: an accepted write sets its vector bit, a read clears its register, a colliding write survives the clear, and an untouched register holds its value. They also check that out-of-range write data and writes to non-index regions leave the interrupt lines unchanged, and that unmapped reads return zero. The bench scenarios show the rest. They cover the exact offset encoding for every group, the summary contents and the per-group interrupt mapping. They also confirm that an unmapped read has no side effect, by reading the real register afterwards, and that reset in the middle of activity drops all state.

// File: rtl/msi_term_pkg.sv
package msi_term_pkg;

    // Default geometry of the bank.
    localparam int unsigned DEF_GROUPS        = 16;
    localparam int unsigned DEF_IDX_PER_GROUP = 8;
    localparam int unsigned DEF_VEC_PER_IDX   = 16;
    localparam int unsigned DEF_REG_SHIFT     = 16;
    localparam int unsigned DEF_DATA_W        = 32;

    // Region selected by a byte offset.
    typedef enum logic [1:0] {
        RGN_NONE    = 2'd0,
        RGN_INDEX   = 2'd1,
        RGN_SUMMARY = 2'd2
    } region_e;

endpackage

// File: rtl/msi_addr_decode.sv
module msi_addr_decode
    import msi_term_pkg::*;
#(
    parameter int unsigned GROUPS        = DEF_GROUPS,
    parameter int unsigned IDX_PER_GROUP = DEF_IDX_PER_GROUP,
    parameter int unsigned REG_SHIFT     = DEF_REG_SHIFT,
    localparam int unsigned GRP_W        = $clog2(GROUPS),
    localparam int unsigned IDX_W        = $clog2(IDX_PER_GROUP),
    localparam int unsigned ADDR_W       = REG_SHIFT + IDX_W + GRP_W + 1
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [GRP_W-1:0]  grp,
    output logic [IDX_W-1:0]  idx
);

    logic [REG_SHIFT-1:0] low_bits;
    logic [IDX_W-1:0]     idx_field;
    logic [GRP_W-1:0]     grp_field;
    logic [GRP_W-1:0]     sum_grp_field;
    logic [ADDR_W-1:0]    sum_upper;

    assign low_bits      = addr[REG_SHIFT-1:0];
    assign idx_field     = addr[REG_SHIFT +: IDX_W];
    assign grp_field     = addr[REG_SHIFT+IDX_W +: GRP_W];
    assign sum_grp_field = addr[REG_SHIFT +: GRP_W];
    assign sum_upper     = addr >> (REG_SHIFT + GRP_W);

    always_comb begin
        region = RGN_NONE;
        grp    = '0;
        idx    = '0;
        if (low_bits == '0) begin
            if (!addr[ADDR_W-1]) begin
                if (32'(grp_field) < GROUPS) begin
                    region = RGN_INDEX;
                    grp    = grp_field;
                    idx    = idx_field;
                end
            end else if (sum_upper == (ADDR_W'(1) << IDX_W)) begin
                if (32'(sum_grp_field) < GROUPS) begin
                    region = RGN_SUMMARY;
                    grp    = sum_grp_field;
                end
            end
        end
    end

endmodule

// File: rtl/msi_term_group.sv
module msi_term_group
    import msi_term_pkg::*;
#(
    parameter int unsigned IDX_PER_GROUP = DEF_IDX_PER_GROUP,
    parameter int unsigned VEC_PER_IDX   = DEF_VEC_PER_IDX,
    localparam int unsigned VEC_W        = $clog2(VEC_PER_IDX),
    localparam int unsigned FLAT_W       = IDX_PER_GROUP * VEC_PER_IDX
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [IDX_PER_GROUP-1:0] wr_sel,
    input  logic [VEC_W-1:0]         wr_vec,
    input  logic [IDX_PER_GROUP-1:0] rd_sel,
    output logic [FLAT_W-1:0]        regs_flat,
    output logic [IDX_PER_GROUP-1:0] summary,
    output logic                     irq
);

    typedef struct packed {
        logic [IDX_PER_GROUP-1:0][VEC_PER_IDX-1:0] regs;
    } grp_state_t;

    grp_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < int'(IDX_PER_GROUP); i++) begin
            if (rd_sel[i]) begin
                state_d.regs[i] = '0;
            end
            if (wr_sel[i]) begin
                state_d.regs[i][wr_vec] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    for (genvar gi = 0; gi < int'(IDX_PER_GROUP); gi++) begin : g_sum
        assign summary[gi] = |state_q.regs[gi];
    end

    assign regs_flat = state_q.regs;
    assign irq       = |summary;

    for (genvar ai = 0; ai < int'(IDX_PER_GROUP); ai++) begin : g_chk
        p_write_sets_r1: assert property (@(posedge clk) disable iff (rst)
            wr_sel[ai] |=> state_q.regs[ai][$past(wr_vec)]);
        p_read_clears_r2: assert property (@(posedge clk) disable iff (rst)
            (rd_sel[ai] && !wr_sel[ai]) |=> (state_q.regs[ai] == '0));
        p_collision_keeps_r5: assert property (@(posedge clk) disable iff (rst)
            (rd_sel[ai] && wr_sel[ai]) |=>
                (state_q.regs[ai] == (VEC_PER_IDX'(1) << $past(wr_vec))));
        p_idle_holds_r1: assert property (@(posedge clk) disable iff (rst)
            (!rd_sel[ai] && !wr_sel[ai]) |=> $stable(state_q.regs[ai]));
    end

endmodule

// File: rtl/msi_term_bank.sv
module msi_term_bank
    import msi_term_pkg::*;
#(
    parameter int unsigned GROUPS        = DEF_GROUPS,
    parameter int unsigned IDX_PER_GROUP = DEF_IDX_PER_GROUP,
    parameter int unsigned VEC_PER_IDX   = DEF_VEC_PER_IDX,
    parameter int unsigned REG_SHIFT     = DEF_REG_SHIFT,
    parameter int unsigned DATA_W        = DEF_DATA_W
) (
    input  logic                                                       clk,
    input  logic                                                       rst,
    input  logic                                                       wr_en,
    input  logic [REG_SHIFT+$clog2(IDX_PER_GROUP)+$clog2(GROUPS):0]    wr_addr,
    input  logic [DATA_W-1:0]                                          wr_data,
    input  logic                                                       rd_en,
    input  logic [REG_SHIFT+$clog2(IDX_PER_GROUP)+$clog2(GROUPS):0]    rd_addr,
    output logic [DATA_W-1:0]                                          rd_data,
    output logic [GROUPS-1:0]                                          irq
);

    localparam int unsigned GRP_W  = $clog2(GROUPS);
    localparam int unsigned IDX_W  = $clog2(IDX_PER_GROUP);
    localparam int unsigned VEC_W  = $clog2(VEC_PER_IDX);
    localparam int unsigned FLAT_W = IDX_PER_GROUP * VEC_PER_IDX;

    typedef struct packed {
        logic [DATA_W-1:0] rd_data;
    } top_state_t;

    top_state_t state_d, state_q;

    region_e          wr_region, rd_region;
    logic [GRP_W-1:0] wr_grp, rd_grp;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic             wr_accept;
    logic             rd_index_hit;
    logic [VEC_W-1:0] wr_vec;

    logic [GROUPS-1:0][FLAT_W-1:0]        regs_all;
    logic [GROUPS-1:0][IDX_PER_GROUP-1:0] sum_all;

    msi_addr_decode #(
        .GROUPS       (GROUPS),
        .IDX_PER_GROUP(IDX_PER_GROUP),
        .REG_SHIFT    (REG_SHIFT)
    ) i_wr_dec (
        .addr  (wr_addr),
        .region(wr_region),
        .grp   (wr_grp),
        .idx   (wr_idx)
    );

    msi_addr_decode #(
        .GROUPS       (GROUPS),
        .IDX_PER_GROUP(IDX_PER_GROUP),
        .REG_SHIFT    (REG_SHIFT)
    ) i_rd_dec (
        .addr  (rd_addr),
        .region(rd_region),
        .grp   (rd_grp),
        .idx   (rd_idx)
    );

    assign wr_accept    = wr_en && (wr_region == RGN_INDEX) &&
                          (wr_data < DATA_W'(VEC_PER_IDX));
    assign rd_index_hit = rd_en && (rd_region == RGN_INDEX);
    assign wr_vec       = wr_data[VEC_W-1:0];

    for (genvar g = 0; g < int'(GROUPS); g++) begin : g_grp
        logic [IDX_PER_GROUP-1:0] wr_sel;
        logic [IDX_PER_GROUP-1:0] rd_sel;

        assign wr_sel = (wr_accept && (wr_grp == GRP_W'(g)))
                        ? (IDX_PER_GROUP'(1) << wr_idx) : '0;
        assign rd_sel = (rd_index_hit && (rd_grp == GRP_W'(g)))
                        ? (IDX_PER_GROUP'(1) << rd_idx) : '0;

        msi_term_group #(
            .IDX_PER_GROUP(IDX_PER_GROUP),
            .VEC_PER_IDX  (VEC_PER_IDX)
        ) i_group (
            .clk      (clk),
            .rst      (rst),
            .wr_sel   (wr_sel),
            .wr_vec   (wr_vec),
            .rd_sel   (rd_sel),
            .regs_flat(regs_all[g]),
            .summary  (sum_all[g]),
            .irq      (irq[g])
        );
    end

    always_comb begin
        state_d = state_q;
        if (rd_en) begin
            unique case (rd_region)
                RGN_INDEX:
                    state_d.rd_data = DATA_W'(regs_all[rd_grp][rd_idx*VEC_PER_IDX +: VEC_PER_IDX]);
                RGN_SUMMARY:
                    state_d.rd_data = DATA_W'(sum_all[rd_grp]);
                default:
                    state_d.rd_data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_data = state_q.rd_data;

    p_unmapped_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (rd_region == RGN_NONE)) |=> (rd_data == '0));
    p_big_data_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_data >= DATA_W'(VEC_PER_IDX)) && !rd_en) |=> $stable(irq));
    p_bad_region_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_region != RGN_INDEX) && !rd_en) |=> $stable(irq));

endmodule

// File: tb/test_msi_term_bank.sv
module test_msi_term_bank;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [23:0] wr_addr;
    logic [31:0] wr_data;
    logic        rd_en;
    logic [23:0] rd_addr;
    logic [31:0] rd_data;
    logic [15:0] irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [15:0] mdl [16][8];

    always #10 clk = ~clk;

    msi_term_bank i_msi_term_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .irq    (irq)
    );

    function automatic logic [23:0] idx_off(input int g, input int x);
        return 24'((g << 19) + (x << 16));
    endfunction

    function automatic logic [23:0] sum_off(input int g);
        return 24'(24'h800000 + (g << 16));
    endfunction

    function automatic logic [7:0] mdl_sum(input int g);
        logic [7:0] s;
        for (int x = 0; x < 8; x++) s[x] = (mdl[g][x] != 0);
        return s;
    endfunction

    function automatic logic [15:0] mdl_irq();
        logic [15:0] v;
        for (int g = 0; g < 16; g++) v[g] = (mdl_sum(g) != 0);
        return v;
    endfunction

    task automatic mdl_clear();
        for (int g = 0; g < 16; g++)
            for (int x = 0; x < 8; x++) mdl[g][x] = '0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [23:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [23:0] a, output logic [31:0] q);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        q = rd_data;
    endtask

    task automatic set_vec(input int g, input int x, input int d);
        do_wr(idx_off(g, x), 32'(d));
        mdl[g][x][d] = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] q;
        chk("R9 rd_data after reset", rd_data, 32'h0);
        chk("R9 irq after reset", 32'(irq), 32'h0);
        do_rd(sum_off(0), q);
        chk("R9 summary after reset", q, 32'h0);
    endtask

    task automatic t_write_read();
        logic [31:0] q;
        set_vec(3, 5, 9);
        chk("R4 irq after write", 32'(irq), 32'(mdl_irq()));
        do_rd(sum_off(3), q);
        chk("R3 summary grp3", q, 32'(mdl_sum(3)));
        do_rd(idx_off(3, 5), q);
        chk("R2 read value", q, 32'h0200);
        mdl[3][5] = '0;
        chk("R4 irq after clear", 32'(irq), 32'(mdl_irq()));
        do_rd(idx_off(3, 5), q);
        chk("R2 second read empty", q, 32'h0);
    endtask

    task automatic t_multi();
        logic [31:0] q;
        set_vec(0, 0, 0);
        set_vec(0, 0, 15);
        set_vec(0, 7, 4);
        set_vec(15, 7, 15);
        set_vec(8, 2, 1);
        chk("R4 irq multi", 32'(irq), 32'(mdl_irq()));
        do_rd(sum_off(0), q);
        chk("R3 summary grp0", q, 32'(mdl_sum(0)));
        do_rd(sum_off(0), q);
        chk("R3 summary read no clear", q, 32'(mdl_sum(0)));
        do_rd(idx_off(0, 0), q);
        chk("R1 two bits same reg", q, 32'h8001);
        mdl[0][0] = '0;
        do_rd(idx_off(0, 7), q);
        chk("R1 grp0 idx7", q, 32'h0010);
        mdl[0][7] = '0;
        do_rd(idx_off(15, 7), q);
        chk("R1 grp15 idx7", q, 32'h8000);
        mdl[15][7] = '0;
        do_rd(idx_off(8, 2), q);
        chk("R1 grp8 idx2", q, 32'h0002);
        mdl[8][2] = '0;
        chk("R4 irq drained", 32'(irq), 32'h0);
    endtask

    task automatic t_collision();
        logic [31:0] q;
        set_vec(6, 3, 2);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = idx_off(6, 3); wr_data = 32'd7;
        rd_en = 1'b1; rd_addr = idx_off(6, 3);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R5 collision old value", rd_data, 32'h0004);
        chk("R5 irq stays", 32'(irq[6]), 32'h1);
        do_rd(idx_off(6, 3), q);
        chk("R5 new bit survives", q, 32'h0080);
        mdl[6][3] = '0;
    endtask

    task automatic t_bad_data();
        logic [31:0] q;
        do_wr(idx_off(2, 1), 32'd16);
        do_wr(idx_off(2, 1), 32'hFFFF_FFFF);
        chk("R6 irq unchanged", 32'(irq), 32'h0);
        do_rd(idx_off(2, 1), q);
        chk("R6 reg untouched", q, 32'h0);
    endtask

    task automatic t_bad_addr();
        logic [31:0] q;
        do_wr(sum_off(4), 32'd3);
        do_wr(idx_off(4, 0) | 24'h000004, 32'd3);
        do_wr(24'h900000, 32'd3);
        do_wr(24'hF40000, 32'd3);
        chk("R7 irq unchanged", 32'(irq), 32'h0);
        do_rd(idx_off(4, 0), q);
        chk("R7 reg untouched", q, 32'h0);
    endtask

    task automatic t_unmapped_read();
        logic [31:0] q;
        set_vec(0, 0, 11);
        do_rd(24'h000004, q);
        chk("R8 unmapped low bits", q, 32'h0);
        do_rd(24'h930000, q);
        chk("R8 unmapped high region", q, 32'h0);
        chk("R8 irq unaffected", 32'(irq), 32'(mdl_irq()));
        do_rd(idx_off(0, 0), q);
        chk("R8 real reg intact", q, 32'h0800);
        mdl[0][0] = '0;
    endtask

    task automatic t_sweep();
        logic [31:0] q;
        for (int g = 0; g < 16; g++) set_vec(g, g % 8, (g * 5) % 16);
        chk("R4 irq all groups", 32'(irq), 32'hFFFF);
        for (int g = 0; g < 16; g++) begin
            do_rd(sum_off(g), q);
            chk("R3 summary sweep", q, 32'(mdl_sum(g)));
            do_rd(idx_off(g, g % 8), q);
            chk("R1 offset sweep", q, 32'(16'(1) << ((g * 5) % 16)));
            mdl[g][g % 8] = '0;
            chk("R4 irq sweep", 32'(irq), 32'(mdl_irq()));
        end
    endtask

    task automatic t_reset_mid();
        logic [31:0] q;
        set_vec(9, 4, 6);
        set_vec(1, 1, 1);
        do_rd(sum_off(9), q);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        mdl_clear();
        chk("R9 irq after mid reset", 32'(irq), 32'h0);
        chk("R9 rd_data after mid reset", rd_data, 32'h0);
        do_rd(idx_off(9, 4), q);
        chk("R9 reg cleared", q, 32'h0);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_en = 1'b0; rd_addr = '0;
        mdl_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write_read();
        t_multi();
        t_collision();
        t_bad_data();
        t_bad_addr();
        t_unmapped_read();
        t_sweep();
        t_reset_mid();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule